// File: doc/BRIEF.md
# Serial Programming Data-EEPROM Read Sequencer

This block is the host side of a two-wire serial programming link. One output carries the programming clock. A second line carries data in both directions. The block uses this link to read bytes out of the data EEPROM of a target that is already in programming mode. A request gives a start address and a byte count. For every byte, the block sends a fixed series of frames. Each frame is a 4-bit command followed by a 16-bit operand, both shifted least-significant bit first. The last frame of each byte hands the data line to the target and captures the byte that comes back.

The first byte of a request needs the full setup. That is seven core-instruction frames (command 0000), then one shift-out frame (command 0010). Each later byte skips the first two setup frames and restarts at the frame that loads the address, with the address one higher. Each captured byte appears on a one-cycle valid strobe. A one-cycle done strobe closes the request.

Clock high and low times, the extra low time after the command nibble, and the extra low time at the bus turnaround are parameters counted in system-clock cycles.

Top module: `sp_eeread_host`

## Requirements
- R1: While reset is high and after reset, pclk_o, pdat_o, pdat_oe_o, busy_o, byte_valid_o and done_o are all 0. While busy_o is 0, pclk_o and pdat_oe_o stay 0.
- R2: Every frame consists of 20 programming clocks: first the 4 command bits, then the 16 operand bits, both least-significant bit first. pdat_o takes each new bit in the cycle pclk_o rises and holds it while pclk_o is high. pclk_o stays high for exactly CLK_HALF cycles and low for exactly CLK_HALF cycles between clocks, except where R3 or R5 apply. pdat_oe_o is 1 whenever the host drives a bit.
- R3: Between the 4th and 5th clock of every frame, pclk_o stays low for exactly CLK_HALF+CMD_GAP cycles.
- R4: The first byte of a request is preceded by seven frames with command 0000. Their operands, in order, are 9EA6, 9CA6, {0E, address}, 6EA9, 80A6, 50A8 and 6EF5 (hex). These are followed by a frame with command 0010.
- R5: In a command-0010 frame, the host drives 0 on the first 8 operand bits. It drops pdat_oe_o in the cycle the 8th operand clock falls. pclk_o then stays low for exactly CLK_HALF+TURN_GAP cycles before the 9th operand clock. pdat_oe_o stays 0 for the last 8 operand clocks.
- R6: The host samples pdat_i when each of the last 8 operand clocks falls. The first of these bits is bit 0 of byte_o. The lower 8 operand bits of the shift-out are discarded.
- R7: byte_valid_o pulses for exactly one cycle per byte, with the captured byte on byte_o.
- R8: Each byte after the first repeats the sequence from the {0E, address} frame, with the address increased by 1 modulo 256.
- R9: done_o pulses for one cycle after count_i bytes. It comes in the same cycle as the last byte_valid_o, with busy_o already 0.
- R10: start_i is ignored while busy_o is 1.
- R11: A request with count_i = 0 gives a done_o pulse in the cycle after start_i, with no programming clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| addr_i | input | 8 | First EEPROM address of the request |
| count_i | input | CNT_W (9) | Number of bytes to read |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle end-of-request strobe |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| byte_o | output | 8 | Byte read from the target |
| pclk_o | output | 1 | Programming clock |
| pdat_o | output | 1 | Data driven toward the target |
| pdat_oe_o | output | 1 | Host drives the data line when 1 |
| pdat_i | input | 1 | Data line as seen by the host |

## Verification
The hardest conditions to reach from the ports lie in the middle of a long multi-byte request. The 8-bit address rolls over from FF to 00 there, and a stray start_i can arrive while the frame sequencer sits between frames. The stimulus reaches these points in three ways. The bench model of the target decodes each address-load frame and serves its own arithmetic memory pattern, so each byte is checked against the address the target actually saw. One request reads all 256 addresses in one go, and another starts at FE. A second start_i pulse, with a different address and count, is injected hundreds of cycles into a request.

// File: rtl/sp_eeread_pkg.sv
package sp_eeread_pkg;

    localparam int CMD_W     = 4;
    localparam int OPD_W     = 16;
    localparam int FRAME_W   = CMD_W + OPD_W;
    localparam int ADDR_W    = 8;
    localparam int STEP_W    = 3;
    localparam int BYTE_W    = 8;

    // step at which each later byte restarts (address load)
    localparam logic [STEP_W-1:0] RELOAD_STEP = 3'd2;
    localparam logic [STEP_W-1:0] FINAL_STEP  = 3'd7;

    typedef enum logic [CMD_W-1:0] {
        CMD_CORE  = 4'b0000,
        CMD_SHOUT = 4'b0010
    } cmd_e;

    typedef struct packed {
        cmd_e             cmd;
        logic [OPD_W-1:0] opd;
        logic             rdbk;
    } xfer_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW,
        PH_CGAP,
        PH_TURN
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } seq_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // frame contents for each step of one byte read
    function automatic xfer_t step_xfer(input logic [STEP_W-1:0] step,
                                        input logic [ADDR_W-1:0] addr);
        xfer_t x;
        x.cmd  = CMD_CORE;
        x.rdbk = 1'b0;
        case (step)
            3'd0:    x.opd = 16'h9EA6;
            3'd1:    x.opd = 16'h9CA6;
            3'd2:    x.opd = {8'h0E, addr};
            3'd3:    x.opd = 16'h6EA9;
            3'd4:    x.opd = 16'h80A6;
            3'd5:    x.opd = 16'h50A8;
            3'd6:    x.opd = 16'h6EF5;
            default: begin
                x.cmd  = CMD_SHOUT;
                x.opd  = '0;
                x.rdbk = 1'b1;
            end
        endcase
        return x;
    endfunction

endpackage

// File: rtl/sp_bit_shifter.sv
module sp_bit_shifter
    import sp_eeread_pkg::*;
#(
    parameter int CLK_HALF = 4,
    parameter int CMD_GAP  = 2,
    parameter int TURN_GAP = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  xfer_t               req,
    input  logic                pdat_in,
    output logic                pclk,
    output logic                pdat,
    output logic                pdat_oe,
    output logic [BYTE_W-1:0]   rbyte,
    output logic                fin
);

    localparam int TMR_MAX = max3(CLK_HALF, CMD_GAP, TURN_GAP);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int BIT_W   = $clog2(FRAME_W);

    localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(CLK_HALF - 1);
    localparam logic [TMR_W-1:0] CGAP_LD = TMR_W'(CMD_GAP - 1);
    localparam logic [TMR_W-1:0] TURN_LD = TMR_W'(TURN_GAP - 1);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] TURN_BIT = BIT_W'(CMD_W + OPD_W/2 - 1);
    localparam logic [BIT_W-1:0] FIRST_IN = BIT_W'(CMD_W + OPD_W/2);

    phase_e             ph;
    logic [FRAME_W-1:0] sreg;
    logic [BIT_W-1:0]   bidx;
    logic [TMR_W-1:0]   tmr;
    logic               rdbk;
    logic               tmr_zero;
    logic               low_end;
    logic               do_rise;

    assign tmr_zero = (tmr == '0);
    assign low_end  = (ph == PH_LOW) && tmr_zero;

    always_comb begin
        do_rise = 1'b0;
        if (low_end) begin
            do_rise = !((bidx == LAST_BIT) || (bidx == CMD_LAST) ||
                        (rdbk && (bidx == TURN_BIT)));
        end else if ((ph == PH_CGAP) || (ph == PH_TURN)) begin
            do_rise = tmr_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            sreg    <= '0;
            bidx    <= '0;
            tmr     <= '0;
            rdbk    <= 1'b0;
            pclk    <= 1'b0;
            pdat    <= 1'b0;
            pdat_oe <= 1'b0;
            rbyte   <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (go) begin
                        sreg    <= {req.opd, req.cmd};
                        rdbk    <= req.rdbk;
                        bidx    <= '0;
                        pclk    <= 1'b1;
                        pdat    <= req.cmd[0];
                        pdat_oe <= 1'b1;
                        tmr     <= HALF_LD;
                        ph      <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tmr_zero) begin
                        pclk <= 1'b0;
                        if (rdbk && (bidx >= FIRST_IN))
                            rbyte <= {pdat_in, rbyte[BYTE_W-1:1]};
                        if (rdbk && (bidx == TURN_BIT))
                            pdat_oe <= 1'b0;
                        tmr <= HALF_LD;
                        ph  <= PH_LOW;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (!tmr_zero) begin
                        tmr <= tmr - 1'b1;
                    end else if (bidx == LAST_BIT) begin
                        fin     <= 1'b1;
                        pdat    <= 1'b0;
                        pdat_oe <= 1'b0;
                        ph      <= PH_IDLE;
                    end else if (bidx == CMD_LAST) begin
                        tmr <= CGAP_LD;
                        ph  <= PH_CGAP;
                    end else if (rdbk && (bidx == TURN_BIT)) begin
                        tmr <= TURN_LD;
                        ph  <= PH_TURN;
                    end
                end
                PH_CGAP, PH_TURN: begin
                    if (!tmr_zero)
                        tmr <= tmr - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase

            if (do_rise) begin
                bidx <= bidx + 1'b1;
                sreg <= sreg >> 1;
                pdat <= sreg[1];
                pclk <= 1'b1;
                tmr  <= HALF_LD;
                ph   <= PH_HIGH;
            end
        end
    end

endmodule

// File: rtl/sp_step_ctrl.sv
module sp_step_ctrl
    import sp_eeread_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [CNT_W-1:0]    count_in,
    input  logic                fin,
    input  logic [BYTE_W-1:0]   rbyte,
    output logic                go,
    output xfer_t               req,
    output logic                busy,
    output logic                byte_valid,
    output logic [BYTE_W-1:0]   byte_out,
    output logic                done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_e              st;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;

    assign req  = step_xfer(step, cur_addr);
    assign go   = (st == SQ_ISSUE);
    assign busy = (st != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            step       <= '0;
            cur_addr   <= '0;
            remain     <= '0;
            byte_valid <= 1'b0;
            byte_out   <= '0;
            done       <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            done       <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        cur_addr <= addr_in;
                        remain   <= count_in;
                        step     <= '0;
                        if (count_in == '0)
                            done <= 1'b1;
                        else
                            st <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (fin) begin
                        if (step != FINAL_STEP) begin
                            step <= step + 1'b1;
                            st   <= SQ_ISSUE;
                        end else begin
                            byte_valid <= 1'b1;
                            byte_out   <= rbyte;
                            if (remain == ONE) begin
                                done <= 1'b1;
                                st   <= SQ_IDLE;
                            end else begin
                                remain   <= remain - 1'b1;
                                cur_addr <= cur_addr + 1'b1;
                                step     <= RELOAD_STEP;
                                st       <= SQ_ISSUE;
                            end
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sp_eeread_host.sv
module sp_eeread_host
    import sp_eeread_pkg::*;
#(
    parameter int CLK_HALF = 4,
    parameter int CMD_GAP  = 2,
    parameter int TURN_GAP = 2,
    parameter int CNT_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o,
    output logic              pclk_o,
    output logic              pdat_o,
    output logic              pdat_oe_o,
    input  logic              pdat_i
);

    logic              go;
    xfer_t             req;
    logic              fin;
    logic [BYTE_W-1:0] rbyte;

    sp_step_ctrl #(
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .addr_in    (addr_i),
        .count_in   (count_i),
        .fin        (fin),
        .rbyte      (rbyte),
        .go         (go),
        .req        (req),
        .busy       (busy_o),
        .byte_valid (byte_valid_o),
        .byte_out   (byte_o),
        .done       (done_o)
    );

    sp_bit_shifter #(
        .CLK_HALF(CLK_HALF),
        .CMD_GAP (CMD_GAP),
        .TURN_GAP(TURN_GAP)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .req     (req),
        .pdat_in (pdat_i),
        .pclk    (pclk_o),
        .pdat    (pdat_o),
        .pdat_oe (pdat_oe_o),
        .rbyte   (rbyte),
        .fin     (fin)
    );

endmodule

// File: rtl/sp_eeread_checks.sv
module sp_eeread_checks #(
    parameter int CLK_HALF = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic bvalid,
    input logic pclk,
    input logic pdat,
    input logic oe
);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)       hi_run <= '0;
        else if (pclk) hi_run <= hi_run + 1'b1;
        else           hi_run <= '0;
    end

    // R1: idle means a quiet link
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pclk && !oe));

    // R2: bit held while clock high
    p_hold_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (pclk && $past(pclk)) |-> $stable(pdat));

    // R2: clock high width
    p_high_width_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(pclk) |-> (hi_run == 16'(CLK_HALF)));

    // R7: one-cycle byte strobe
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        bvalid |=> !bvalid);

    // R9: one-cycle done with block idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind sp_eeread_host sp_eeread_checks #(
    .CLK_HALF(CLK_HALF)
) u_checks (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy_o),
    .done   (done_o),
    .bvalid (byte_valid_o),
    .pclk   (pclk_o),
    .pdat   (pdat_o),
    .oe     (pdat_oe_o)
);

// File: tb/tb_sp_eeread_host.sv
module tb_sp_eeread_host;

    localparam int CH = 2;
    localparam int CG = 2;
    localparam int TG = 3;
    localparam int CW = 9;
    localparam int WDOG = 195000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [7:0]    addr_i = '0;
    logic [CW-1:0] count_i = '0;
    logic          busy_o, done_o, byte_valid_o;
    logic [7:0]    byte_o;
    logic          pclk_o, pdat_o, pdat_oe_o;
    logic          pdat_i = 1'b0;

    sp_eeread_host #(
        .CLK_HALF(CH), .CMD_GAP(CG), .TURN_GAP(TG), .CNT_W(CW)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
        .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
        .byte_valid_o(byte_valid_o), .byte_o(byte_o), .pclk_o(pclk_o),
        .pdat_o(pdat_o), .pdat_oe_o(pdat_oe_o), .pdat_i(pdat_i)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] tmem(input int a);
        return 8'(((a * 37 + 11) ^ (a >> 3)) & 255);
    endfunction

    function automatic logic [15:0] exp_word(input int step, input int a);
        case (step)
            0: return 16'h9EA6;
            1: return 16'h9CA6;
            2: return {8'h0E, 8'(a)};
            3: return 16'h6EA9;
            4: return 16'h80A6;
            5: return 16'h50A8;
            6: return 16'h6EF5;
            default: return 16'h0000;
        endcase
    endfunction

    // monitor / target model state
    logic        prev_pclk = 1'b0;
    logic        prev_valid = 1'b0;
    int          hi_cnt = 0, lo_cnt = 0, fidx = 0, rises = 0;
    logic [19:0] fbits = '0;
    logic [7:0]  t_byte = '0;
    int          m_step = 0, m_addr = 0, m_first = 1;
    int          base = 0, nbytes = 0, exp_count = 0;
    bit          done_seen = 0;

    task automatic frame_done();
        logic [3:0]  cmd;
        logic [15:0] opd;
        string       tag;
        cmd = fbits[3:0];
        opd = fbits[19:4];
        tag = m_first ? "R4" : "R8";
        if (cmd == 4'b0000 && opd[15:8] == 8'h0E)
            t_byte = tmem(int'(opd[7:0]));
        if (m_step < 7) begin
            chk(cmd == 4'b0000, tag, "core cmd", cmd, 0);
            chk(opd == exp_word(m_step, m_addr), tag, "operand", opd,
                exp_word(m_step, m_addr));
            m_step++;
        end else begin
            chk(cmd == 4'b0010, tag, "shout cmd", cmd, 2);
            chk(opd[7:0] == 8'h00, "R5", "host zeros", opd[7:0], 0);
            m_step  = 2;
            m_addr  = (m_addr + 1) & 255;
            m_first = 0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (pclk_o && !prev_pclk) begin
                rises++;
                if (fidx == 4)
                    chk(lo_cnt == CH + CG, "R3", "cmd gap low", lo_cnt, CH + CG);
                else if (fidx == 12 && fbits[3:0] == 4'b0010)
                    chk(lo_cnt == CH + TG, "R5", "turn low", lo_cnt, CH + TG);
                else if (fidx != 0)
                    chk(lo_cnt == CH, "R2", "low width", lo_cnt, CH);
                fbits[fidx] = pdat_o;
                if (fidx >= 12 && fbits[3:0] == 4'b0010) begin
                    chk(!pdat_oe_o, "R5", "released", pdat_oe_o, 0);
                    pdat_i = t_byte[fidx-12];
                end else begin
                    chk(pdat_oe_o, "R2", "host drives", pdat_oe_o, 1);
                end
                hi_cnt = 1;
                fidx++;
            end else if (!pclk_o && prev_pclk) begin
                chk(hi_cnt == CH, "R2", "high width", hi_cnt, CH);
                if (fidx == 12 && fbits[3:0] == 4'b0010)
                    chk(!pdat_oe_o, "R5", "release at 8th fall", pdat_oe_o, 0);
                if (fidx == 20) begin
                    frame_done();
                    fidx = 0;
                end
                lo_cnt = 1;
            end else if (pclk_o) begin
                hi_cnt++;
            end else begin
                lo_cnt++;
            end
            prev_pclk = pclk_o;

            if (byte_valid_o) begin
                chk(!prev_valid, "R7", "single strobe", prev_valid, 0);
                chk(byte_o == tmem((base + nbytes) & 255), "R6", "byte",
                    byte_o, tmem((base + nbytes) & 255));
                nbytes++;
            end
            if (done_o) begin
                chk(nbytes == exp_count, "R9", "byte count", nbytes, exp_count);
                chk(!busy_o, "R9", "idle at done", busy_o, 0);
                chk(byte_valid_o == (exp_count != 0), "R9", "done with last byte",
                    byte_valid_o, exp_count != 0);
                done_seen = 1;
            end
            prev_valid = byte_valid_o;
        end
    end

    task automatic run_seq(input int a, input int n, input bit poke);
        m_step = 0; m_addr = a; m_first = 1;
        base = a; nbytes = 0; exp_count = n; done_seen = 0;
        @(negedge clk);
        start_i = 1'b1; addr_i = 8'(a); count_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            chk(busy_o, "R10", "busy before poke", busy_o, 1);
            start_i = 1'b1; addr_i = 8'(a ^ 8'h55); count_i = CW'(1);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        if (poke)
            chk(nbytes == n, "R10", "stray start ignored", nbytes, n);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        chk({pclk_o, pdat_o, pdat_oe_o, busy_o, byte_valid_o, done_o} == 6'b0,
            "R1", "outputs in reset",
            {pclk_o, pdat_o, pdat_oe_o, busy_o, byte_valid_o, done_o}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({pclk_o, pdat_oe_o, busy_o, done_o} == 4'b0, "R1", "idle after reset",
            {pclk_o, pdat_oe_o, busy_o, done_o}, 0);

        // R10: stray start mid request
        run_seq(8'h10, 3, 1'b1);
        // R8: address wrap FE -> 01
        run_seq(8'hFE, 4, 1'b0);
        run_seq(8'h7F, 1, 1'b0);

        // R11: zero count
        r0 = rises;
        run_seq(0, 0, 1'b0);
        chk(rises == r0, "R11", "no clocks for zero count", rises - r0, 0);

        // sweep of every address in one request
        run_seq(0, 256, 1'b0);
        chk(nbytes == 256, "R8", "full sweep bytes", nbytes, 256);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule